// File: doc/BRIEF.md
# Keypad Group Select Reader

This block reads eight push-button lines through a narrow 4-bit port. The buttons form two groups of four: the lower half of the key vector is one group and the upper half the other. The processor writes two group-select bits. These bits are active-low, so a 0 in a bit enables that group. The block returns an 8-bit value in which the low four bits show the keys of the enabled group or groups, with a pressed key reading as 0.

The raw key vector is active-high: 1 means pressed. It arrives asynchronously and passes through a two-flop synchronizer before it reaches the read path. When both groups are enabled, the two halves are combined with OR, so a key pressed in either group pulls the matching result bit low. The two top bits of the read value are always 1. The select bits read back in their own positions.

Top module: `keypad_group_reader`

## Requirements
- R1: After a synchronous active-low reset, both select bits (read bits 5:4) are 1 and the read value is 0xFF.
- R2: Read bits 7:6 are always 1.
- R3: Read bits 5:4 always equal the stored select bits.
- R4: With select bits 5:4 = 11, read bits 3:0 are 1111 whatever keys are pressed.
- R5: With select bits 5:4 = 10, read bits 3:0 are the inverse of key vector bits 7:4.
- R6: With select bits 5:4 = 01, read bits 3:0 are the inverse of key vector bits 3:0.
- R7: With select bits 5:4 = 00, read bits 3:0 are the inverse of (key bits 7:4 OR key bits 3:0).
- R8: A write stores only bits 5:4 of the write data. Written bits 7:6 and 3:0 are ignored and have no effect on the read value.
- R9: A change on the raw key input shows in the read value after the second rising clock edge, and not after the first.
- R10: The select bits change only on a clock edge where the write enable is high. With the write enable low, the write data has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the select register |
| wr_data | input | 8 | Write data; only bits 5:4 are used |
| keys_raw | input | 8 | Asynchronous pressed-key vector, 1 = pressed |
| rd_data | output | 8 | Read value |

## Verification
The bench presses keys in both halves at the same time. A design that let the wrong half through, or that gave the wrong polarity to the select bits, would then report keys from the disabled group. With both groups enabled, a key is pressed in only one half of a position. A design that used AND instead of OR would leave that bit high. Writes carry ones in the unused bit positions, which catches a register that stores them. The bench also checks the read value one edge after a key change, which catches a synchronizer with one stage missing.

// File: rtl/kp_pkg.sv
// Shared widths and select encodings for the keypad group reader.
// Assumes two equal key groups packed into one vector, low group in the low half.
package kp_pkg;
    localparam int NIB_W   = 4;
    localparam int KEY_W   = 2 * NIB_W;
    localparam int RD_W    = 8;
    localparam int SEL_LSB = 4;
    typedef logic [1:0] grp_sel_t;
    localparam grp_sel_t SEL_NONE = 2'b11;
    localparam grp_sel_t SEL_HI   = 2'b10;
    localparam grp_sel_t SEL_LO   = 2'b01;
    localparam grp_sel_t SEL_BOTH = 2'b00;
endpackage

// File: rtl/kp_key_sync.sv
// Multi-stage synchronizer for the asynchronous key vector.
// Assumes each key line is a slow level; no debouncing is done here.
module kp_key_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw lines into the first flop
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d_async;
                end
            end else begin : g_next
                // shift the value down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R9
            sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (q_sync == $past(d_async, 2)));
        end
    endgenerate
endmodule

// File: rtl/kp_sel_reg.sv
// Holds the two active-low group-select bits.
// Assumes a single-byte write port; only the select field of the data is stored.
module kp_sel_reg
    import kp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RD_W-1:0] wr_data,
    output grp_sel_t        sel_q
);
    // store the select field on a write; reset to "no group"
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= SEL_NONE;
        else if (wr_en) sel_q <= wr_data[SEL_LSB +: 2];
    end

    // R1
    sel_reset_chk: assert property (@(posedge clk) !rst_n |=> (sel_q == SEL_NONE));
    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));
    // R8
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel_q == $past(wr_data[5:4])));
endmodule

// File: rtl/kp_read_mux.sv
// Picks the enabled key group(s) and forms the active-low read byte.
// Assumes keys are active-high and select bits active-low.
module kp_read_mux
    import kp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  grp_sel_t         sel,
    input  logic [KEY_W-1:0] keys,
    output logic [RD_W-1:0]  rd_data
);
    logic [NIB_W-1:0] lo_grp, hi_grp, picked;

    assign lo_grp = keys[NIB_W-1:0];
    assign hi_grp = keys[KEY_W-1:NIB_W];

    // merge the groups that are enabled (select bit low)
    always_comb begin
        unique case (sel)
            SEL_HI:   picked = hi_grp;
            SEL_LO:   picked = lo_grp;
            SEL_BOTH: picked = hi_grp | lo_grp;
            default:  picked = '0;
        endcase
    end

    // assemble: fixed ones on top, select echo, inverted key field
    assign rd_data = {2'b11, sel, ~picked};

    // R2
    top_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b11);
    // R4
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (rd_data[3:0] == 4'hF));
    // R7
    both_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_BOTH) |-> (rd_data[3:0] == ~(keys[7:4] | keys[3:0])));
endmodule

// File: rtl/keypad_group_reader.sv
// Top: synchronizes the key vector, holds the select bits, returns the read byte.
// Assumes rd_data is sampled combinationally by the bus side.
module keypad_group_reader
    import kp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      keys_raw,
    output logic [7:0]      rd_data
);
    grp_sel_t         sel_q;
    logic [KEY_W-1:0] keys_s;

    kp_key_sync #(.WIDTH(KEY_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_async(keys_raw), .q_sync(keys_s)
    );

    kp_sel_reg i_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sel_q(sel_q)
    );

    kp_read_mux i_mux (
        .clk(clk), .rst_n(rst_n), .sel(sel_q), .keys(keys_s), .rd_data(rd_data)
    );

    // R3
    sel_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:4] == sel_q);
endmodule

// File: tb/test_keypad_group_reader.sv
module test_keypad_group_reader;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] keys_raw = 8'h00;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    keypad_group_reader i_keypad_group_reader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .keys_raw(keys_raw), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model(input logic [1:0] s, input logic [7:0] k);
        logic [3:0] n;
        case (s)
            2'b10:   n = k[7:4];
            2'b01:   n = k[3:0];
            2'b00:   n = k[7:4] | k[3:0];
            default: n = 4'h0;
        endcase
        return {2'b11, s, ~n};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic write_sel(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = ~d;
    endtask

    task automatic set_keys(input logic [7:0] k);
        @(negedge clk); keys_raw = k;
        @(negedge clk); @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 reset value", rd_data, 8'hFF);
        set_keys(8'hA5);
        chk("R4 none selected with keys", rd_data, 8'hFF);
        chk("R2 top bits", {rd_data[7:6], 6'h0}, 8'hC0);
    endtask

    task automatic t_hi;
        write_sel(8'h20);
        set_keys(8'h3C);
        chk("R5 high group 3C", rd_data, model(2'b10, 8'h3C));
        set_keys(8'hF0);
        chk("R5 high group F0", rd_data, model(2'b10, 8'hF0));
        chk("R3 echo 10", rd_data & 8'h30, 8'h20);
    endtask

    task automatic t_lo;
        write_sel(8'h10);
        set_keys(8'h3C);
        chk("R6 low group 3C", rd_data, model(2'b01, 8'h3C));
        set_keys(8'h0F);
        chk("R6 low group 0F", rd_data, model(2'b01, 8'h0F));
        chk("R3 echo 01", rd_data & 8'h30, 8'h10);
    endtask

    task automatic t_both;
        write_sel(8'h00);
        set_keys(8'h12);
        chk("R7 both groups 12", rd_data, 8'hC0 | 8'h0C);
        set_keys(8'h80);
        chk("R7 both groups 80", rd_data, model(2'b00, 8'h80));
        set_keys(8'h00);
        chk("R7 both groups idle", rd_data, 8'hCF);
    endtask

    task automatic t_mask;
        set_keys(8'h21);
        write_sel(8'hCF);
        #1 chk("R8 ignored bits, sel 00", rd_data, model(2'b00, 8'h21));
        write_sel(8'hFF);
        #1 chk("R8 ignored bits, sel 11", rd_data, 8'hFF);
        write_sel(8'h2A);
        #1 chk("R8 ignored bits, sel 10", rd_data, model(2'b10, 8'h21));
    endtask

    task automatic t_latency;
        write_sel(8'h10);
        set_keys(8'h00);
        @(negedge clk); keys_raw = 8'h05;
        @(negedge clk); #1;
        chk("R9 no change after one edge", rd_data, 8'hDF);
        @(negedge clk); #1;
        chk("R9 change after two edges", rd_data, model(2'b01, 8'h05));
    endtask

    task automatic t_no_write;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk); @(negedge clk); #1;
        chk("R10 no write keeps select", rd_data, model(2'b01, 8'h05));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hi();
        t_lo();
        t_both();
        t_mask();
        t_latency();
        t_no_write();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule